// File: doc/BRIEF.md
# Strap-Selected Self-Test Sequencer

This block decides, once per reset, whether a device runs normally or loops through a built-in self-test. The decision comes from the serial receive pin. That pin never carries data here and is used only as a boot-time strap. The pin's level passes through a synchroniser and is latched shortly after reset is released. A low level selects self-test and a high level selects normal operation. Once latched, the choice holds until the next reset.

In normal mode, a byte-wide diagnostic trace stream with a valid/ready handshake is forwarded to a transmit-only UART (8 data bits, no parity, 1 stop bit, idle high). In self-test mode, the trace stream is refused. The sequencer then starts each external test slot in turn through a start/done/pass handshake and bounds each wait with a timeout. It prints a short ASCII verdict line for every slot and then starts over at slot 1, without end.

Top module: `strap_selftest_seq`

## Requirements
- R1: With `rx_strap` low through reset and the first three clock edges after release, `selftest_active` is high after the third edge. It is low during reset.
- R2: With `rx_strap` high at release, the block is in normal mode: `selftest_active` stays low, and every byte accepted on the trace handshake (`trace_valid` and `trace_ready` both high at a clock edge) is sent on `uart_tx` unchanged.
- R3: Once the mode is latched, later changes of `rx_strap` have no effect on the mode until the next reset.
- R4: Each UART frame is one low start bit, 8 data bits LSB first and one high stop bit. Every bit lasts DIV = round(CLK_HZ/BAUD) clocks, which is 2604 at the defaults of 50 MHz and 19200 baud. The line idles high and is high during reset.
- R5: In self-test mode the slots start in index order 0, 1, ..., NUM_TESTS-1. Each start is a single-cycle pulse on exactly one `test_start` bit.
- R6: Each slot's report is the ASCII decimal slot number (index+1), a space (0x20), the word `PASS` or `FAIL`, then CR (0x0D) and LF (0x0A).
- R7: When `test_done[i]` is seen during slot i's wait, the report reads `PASS` if `test_pass[i]` is high in that same cycle and `FAIL` otherwise. A failed slot does not stop the sequence.
- R8: The wait after a start lasts at most TIMEOUT_CYC cycles. A done seen in the last of these cycles still counts. With no done in the window the slot reports `FAIL`, and a later done is ignored.
- R9: A slot's start pulse is issued only after the previous report's final stop bit has left the line.
- R10: After the last slot the sequence restarts at slot 0 and repeats until reset.
- R11: In self-test mode `trace_ready` stays low and trace bytes never reach the line. In normal mode no `test_start` bit is ever asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_strap | input | 1 | Serial receive pin, read only as the boot-mode strap |
| trace_valid | input | 1 | Trace byte offered (normal mode) |
| trace_data | input | 8 | Trace byte value |
| trace_ready | output | 1 | Trace byte taken at this edge when valid |
| test_start | output | NUM_TESTS | One-cycle start pulse per test slot |
| test_done | input | NUM_TESTS | Completion strobe per test slot |
| test_pass | input | NUM_TESTS | Verdict per slot, read together with done |
| selftest_active | output | 1 | Latched self-test mode |
| uart_tx | output | 1 | Serial transmit line |

## Verification
Two things can fall in the same cycle: a slot's done strobe and the expiry of its timeout window. The bench's test stub answers one slot exactly on the last cycle of the window and another slot one cycle later. The first must report PASS and the second FAIL. The late strobe of the second slot arrives while its report is being sent, and the report must come out byte-exact with nothing extra. A second overlap is a strap edge just after the mode latches, which the mode flag must not follow.

// File: rtl/strap_st_pkg.sv
package strap_st_pkg;

    typedef enum logic [2:0] {
        SQ_BOOT,
        SQ_TRACE,
        SQ_LAUNCH,
        SQ_AWAIT,
        SQ_EMIT,
        SQ_DRAIN
    } seq_state_e;

    localparam logic [7:0] CH_ZERO = 8'h30;
    localparam logic [7:0] CH_SP   = 8'h20;
    localparam logic [7:0] CH_CR   = 8'h0D;
    localparam logic [7:0] CH_LF   = 8'h0A;

    // number of bytes in one verdict line for slot number num (1..99)
    function automatic logic [3:0] report_len(input logic [6:0] num);
        return (num >= 7'd10) ? 4'd9 : 4'd8;
    endfunction

    // byte idx of the verdict line for slot number num
    function automatic logic [7:0] report_char(input logic [6:0] num,
                                               input logic       ok,
                                               input logic [3:0] idx);
        logic [6:0] tens;
        logic [6:0] ones;
        logic [3:0] pos;
        logic [7:0] c;
        tens = num / 7'd10;
        ones = num % 7'd10;
        pos  = idx;
        if (num >= 7'd10) begin
            if (idx == 4'd0) begin
                return CH_ZERO + {1'b0, tens};
            end
            pos = idx - 4'd1;
        end
        case (pos)
            4'd0:    c = CH_ZERO + {1'b0, ones};
            4'd1:    c = CH_SP;
            4'd2:    c = ok ? 8'h50 : 8'h46;
            4'd3:    c = 8'h41;
            4'd4:    c = ok ? 8'h53 : 8'h49;
            4'd5:    c = ok ? 8'h53 : 8'h4C;
            4'd6:    c = CH_CR;
            default: c = CH_LF;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/strap_mode_latch.sv
module strap_mode_latch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_i,
    output logic mode_valid_o,
    output logic selftest_o
);
    localparam int FILL_W = $clog2(SYNC_STAGES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [FILL_W-1:0]      fill;
        logic                   valid;
        logic                   selftest;
    } latch_t;

    latch_t latch_d, latch_q;

    always_comb begin
        latch_d      = latch_q;
        latch_d.sync = {latch_q.sync[SYNC_STAGES-2:0], strap_i};
        if (!latch_q.valid) begin
            if (latch_q.fill == FILL_W'(SYNC_STAGES)) begin
                latch_d.valid    = 1'b1;
                latch_d.selftest = !latch_q.sync[SYNC_STAGES-1];
            end else begin
                latch_d.fill = latch_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '{sync: '1, fill: '0, valid: 1'b0, selftest: 1'b0};
        end else begin
            latch_q <= latch_d;
        end
    end

    assign mode_valid_o = latch_q.valid;
    assign selftest_o   = latch_q.selftest;

    // R3: once decided, the mode never moves again
    assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        latch_q.valid |=> (latch_q.valid && $stable(latch_q.selftest)));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int DIV = 2604
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == CNT_W'(DIV - 1));
        if (!run_i || tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core #(
    parameter int DIV = 2604
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       valid_i,
    input  logic [7:0] data_i,
    output logic       ready_o,
    output logic       tx_o
);
    typedef struct packed {
        logic       busy;
        logic [9:0] sh;
        logic [3:0] nbits;
    } txr_t;

    txr_t tx_d, tx_q;
    logic tick;

    baud_tick_gen #(.DIV(DIV)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .run_i (tx_q.busy),
        .tick_o(tick)
    );

    always_comb begin
        tx_d = tx_q;
        if (!tx_q.busy) begin
            if (valid_i) begin
                tx_d.busy  = 1'b1;
                tx_d.sh    = {1'b1, data_i, 1'b0};
                tx_d.nbits = '0;
            end
        end else if (tick) begin
            tx_d.sh = {1'b1, tx_q.sh[9:1]};
            if (tx_q.nbits == 4'd9) begin
                tx_d.busy = 1'b0;
            end else begin
                tx_d.nbits = tx_q.nbits + 4'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '{busy: 1'b0, sh: '1, nbits: '0};
        end else begin
            tx_q <= tx_d;
        end
    end

    assign ready_o = !tx_q.busy;
    assign tx_o    = tx_q.busy ? tx_q.sh[0] : 1'b1;

    // R4: inside a frame the line only moves on a baud tick
    assert_line_holds_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q.busy && !tick) |=> $stable(tx_o));

endmodule

// File: rtl/selftest_sequencer.sv
module selftest_sequencer
    import strap_st_pkg::*;
#(
    parameter int NUM_TESTS   = 10,
    parameter int TIMEOUT_CYC = 100000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_valid_i,
    input  logic                 selftest_i,
    input  logic                 tx_ready_i,
    input  logic [NUM_TESTS-1:0] test_done_i,
    input  logic [NUM_TESTS-1:0] test_pass_i,
    output logic [NUM_TESTS-1:0] test_start_o,
    output logic                 byte_valid_o,
    output logic [7:0]           byte_data_o
);
    localparam int SLOT_W = (NUM_TESTS > 1) ? $clog2(NUM_TESTS) : 1;
    localparam int TMO_W  = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [SLOT_W-1:0] slot;
        logic [TMO_W-1:0]  tmo;
        logic              ok;
        logic [3:0]        chr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [6:0] slot_num;
    logic [3:0] last_chr;

    assign slot_num = 7'(seq_q.slot) + 7'd1;
    assign last_chr = report_len(slot_num) - 4'd1;

    always_comb begin
        seq_d        = seq_q;
        byte_valid_o = 1'b0;
        byte_data_o  = report_char(slot_num, seq_q.ok, seq_q.chr);
        case (seq_q.state)
            SQ_BOOT: begin
                if (mode_valid_i) begin
                    seq_d.state = selftest_i ? SQ_LAUNCH : SQ_TRACE;
                    seq_d.slot  = '0;
                end
            end
            SQ_TRACE: begin
                seq_d.state = SQ_TRACE;
            end
            SQ_LAUNCH: begin
                seq_d.state = SQ_AWAIT;
                seq_d.tmo   = '0;
            end
            SQ_AWAIT: begin
                if (test_done_i[seq_q.slot]) begin
                    seq_d.ok    = test_pass_i[seq_q.slot];
                    seq_d.chr   = '0;
                    seq_d.state = SQ_EMIT;
                end else if (seq_q.tmo == TMO_W'(TIMEOUT_CYC - 1)) begin
                    seq_d.ok    = 1'b0;
                    seq_d.chr   = '0;
                    seq_d.state = SQ_EMIT;
                end else begin
                    seq_d.tmo = seq_q.tmo + 1'b1;
                end
            end
            SQ_EMIT: begin
                byte_valid_o = 1'b1;
                if (tx_ready_i) begin
                    if (seq_q.chr == last_chr) begin
                        seq_d.state = SQ_DRAIN;
                    end else begin
                        seq_d.chr = seq_q.chr + 4'd1;
                    end
                end
            end
            SQ_DRAIN: begin
                if (tx_ready_i) begin
                    seq_d.state = SQ_LAUNCH;
                    seq_d.slot  = (seq_q.slot == SLOT_W'(NUM_TESTS - 1)) ? '0
                                                                         : seq_q.slot + 1'b1;
                end
            end
            default: seq_d.state = SQ_BOOT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SQ_BOOT, slot: '0, tmo: '0, ok: 1'b0, chr: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    for (genvar g = 0; g < NUM_TESTS; g++) begin : g_start
        assign test_start_o[g] = (seq_q.state == SQ_LAUNCH) && (seq_q.slot == SLOT_W'(g));
    end

    // R5: never more than one slot started at a time
    assert_single_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(test_start_o));

    // R9: a slot is only launched with the transmitter idle
    assert_launch_on_quiet_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|test_start_o) |-> tx_ready_i);

    // R11: normal mode never launches tests nor emits reports
    assert_quiet_in_normal_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid_i && !selftest_i) |-> (test_start_o == '0 && !byte_valid_o));

    // R8: the wait never runs past its window
    assert_wait_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == SQ_AWAIT) |-> (seq_q.tmo <= TMO_W'(TIMEOUT_CYC - 1)));

endmodule

// File: rtl/strap_selftest_seq.sv
module strap_selftest_seq #(
    parameter int CLK_HZ      = 50_000_000,
    parameter int BAUD        = 19200,
    parameter int NUM_TESTS   = 10,
    parameter int TIMEOUT_CYC = 100000,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_strap,
    input  logic                 trace_valid,
    input  logic [7:0]           trace_data,
    output logic                 trace_ready,
    output logic [NUM_TESTS-1:0] test_start,
    input  logic [NUM_TESTS-1:0] test_done,
    input  logic [NUM_TESTS-1:0] test_pass,
    output logic                 selftest_active,
    output logic                 uart_tx
);
    localparam int DIV = (CLK_HZ + BAUD / 2) / BAUD;

    logic       mode_valid;
    logic       selftest;
    logic       tx_ready;
    logic       seq_valid;
    logic [7:0] seq_data;
    logic       tx_valid;
    logic [7:0] tx_data;

    strap_mode_latch #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (rx_strap),
        .mode_valid_o(mode_valid),
        .selftest_o  (selftest)
    );

    selftest_sequencer #(
        .NUM_TESTS  (NUM_TESTS),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_valid_i(mode_valid),
        .selftest_i  (selftest),
        .tx_ready_i  (tx_ready),
        .test_done_i (test_done),
        .test_pass_i (test_pass),
        .test_start_o(test_start),
        .byte_valid_o(seq_valid),
        .byte_data_o (seq_data)
    );

    assign selftest_active = mode_valid && selftest;
    assign trace_ready     = mode_valid && !selftest && tx_ready;
    assign tx_valid        = seq_valid || (trace_valid && trace_ready);
    assign tx_data         = seq_valid ? seq_data : trace_data;

    uart_tx_core #(.DIV(DIV)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid_i(tx_valid),
        .data_i (tx_data),
        .ready_o(tx_ready),
        .tx_o   (uart_tx)
    );

    // R11: the trace path is closed while self-test runs
    assert_trace_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        selftest_active |-> !trace_ready);

endmodule

// File: tb/sim_strap_selftest_seq.sv
`timescale 1ns/1ps
module sim_strap_selftest_seq;
    localparam int NT    = 10;
    localparam int DIV_T = 8;
    localparam int TMO   = 20;
    // stimulus table: response delay per slot (0 = never answers) and pass level
    localparam int DLY [NT] = '{1, 3, 5, 20, 21, 0, 2, 7, 4, 19};
    localparam bit OKT [NT] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_strap = 1'b1;
    logic          trace_valid = 1'b0;
    logic [7:0]    trace_data = 8'h00;
    logic          trace_ready;
    logic [NT-1:0] test_start;
    logic [NT-1:0] test_done = '0;
    logic [NT-1:0] test_pass = '0;
    logic          selftest_active;
    logic          uart_tx;

    strap_selftest_seq #(
        .CLK_HZ(800), .BAUD(100), .NUM_TESTS(NT), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .rx_strap(rx_strap),
        .trace_valid(trace_valid), .trace_data(trace_data), .trace_ready(trace_ready),
        .test_start(test_start), .test_done(test_done), .test_pass(test_pass),
        .selftest_active(selftest_active), .uart_tx(uart_tx)
    );

    always #2.5 clk = ~clk;

    int errors = 0;
    int checks = 0;

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // serial receiver model
    logic [7:0] rx_buf [0:255];
    int rx_count = 0;
    int frame_errs = 0;
    bit rx_busy = 1'b0;
    initial begin
        logic [7:0] b;
        forever begin
            @(negedge clk);
            if (rst_n && uart_tx == 1'b0) begin
                rx_busy = 1'b1;
                repeat (DIV_T / 2) @(negedge clk);
                for (int k = 0; k < 8; k++) begin
                    repeat (DIV_T) @(negedge clk);
                    b[k] = uart_tx;
                end
                repeat (DIV_T) @(negedge clk);
                if (uart_tx != 1'b1) frame_errs++;
                repeat (DIV_T / 2 - 1) @(negedge clk);
                if (rx_count < 256) rx_buf[rx_count] = b;
                rx_count++;
                rx_busy = 1'b0;
            end
        end
    end

    // external test stubs
    int order_log [0:31];
    int n_starts = 0;
    int pend_cnt = 0;
    int pend_slot = 0;
    bit pend = 1'b0;
    int r9_bad = 0;
    int tr_bad = 0;
    always @(negedge clk) begin
        test_done = '0;
        if (selftest_active && trace_ready) tr_bad++;
        if (!rst_n) begin
            pend = 1'b0;
        end else begin
            if (pend) begin
                pend_cnt--;
                if (pend_cnt == 0) begin
                    test_pass[pend_slot] = OKT[pend_slot];
                    test_done[pend_slot] = 1'b1;
                    pend = 1'b0;
                end
            end
            if (test_start != '0) begin
                for (int i = 0; i < NT; i++) if (test_start[i]) pend_slot = i;
                if (n_starts < 32) order_log[n_starts] = pend_slot;
                n_starts++;
                if (rx_busy) r9_bad++;
                if (DLY[pend_slot] > 0) begin
                    pend = 1'b1;
                    pend_cnt = DLY[pend_slot];
                end
            end
        end
    end

    task automatic send_trace(input logic [7:0] v, output int low_width);
        @(negedge clk);
        trace_valid = 1'b1;
        trace_data  = v;
        while (!trace_ready) @(negedge clk);
        @(negedge clk);
        trace_valid = 1'b0;
        low_width = 0;
        while (uart_tx == 1'b0) begin
            low_width++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        int w;
        int sbase;
        int n_exp;
        logic [7:0] exp_buf [0:127];
        string exp_tag [0:127];
        logic [7:0] tv [3];
        tv = '{8'h01, 8'hA5, 8'h3C};

        // ---------- reset state ----------
        repeat (4) @(negedge clk);
        check_eq("R4", "tx idle high in reset", int'(uart_tx), 1);
        check_eq("R5", "no start in reset", int'(test_start), 0);
        check_eq("R1", "mode low in reset", int'(selftest_active), 0);
        check_eq("R2", "trace_ready low in reset", int'(trace_ready), 0);

        // ---------- normal mode ----------
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_eq("R2", "normal mode selected", int'(selftest_active), 0);
        check_eq("R2", "trace path open", int'(trace_ready), 1);
        rx_strap = 1'b0;
        repeat (5) @(negedge clk);
        base = rx_count;
        for (int i = 0; i < 3; i++) begin
            send_trace(tv[i], w);
            if (i == 0) check_eq("R4", "start bit width in clocks", w, DIV_T);
        end
        while (rx_count < base + 3) @(negedge clk);
        for (int i = 0; i < 3; i++)
            check_eq("R2", $sformatf("trace byte %0d", i), int'(rx_buf[base + i]), int'(tv[i]));
        check_eq("R3", "strap edge ignored after latch", int'(selftest_active), 0);
        check_eq("R11", "no test start in normal mode", n_starts, 0);
        check_eq("R4", "framing errors normal", frame_errs, 0);

        // ---------- self-test mode ----------
        rst_n = 1'b0;
        trace_valid = 1'b1;
        trace_data = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        base = rx_count;
        sbase = n_starts;
        repeat (3) @(negedge clk);
        check_eq("R1", "self-test latched after three edges", int'(selftest_active), 1);
        rx_strap = 1'b1;

        // expected report stream, walked from the table
        n_exp = 0;
        for (int s = 0; s < NT; s++) begin
            bit answered;
            bit ok;
            string line;
            answered = (DLY[s] > 0) && (DLY[s] <= TMO);
            ok = answered && OKT[s];
            line = $sformatf("%0d %s\r\n", s + 1, ok ? "PASS" : "FAIL");
            for (int c = 0; c < line.len(); c++) begin
                exp_buf[n_exp] = line[c];
                exp_tag[n_exp] = answered ? "R7" : "R8";
                n_exp++;
            end
        end
        exp_buf[n_exp] = 8'h31; exp_tag[n_exp] = "R10"; n_exp++;
        exp_buf[n_exp] = 8'h20; exp_tag[n_exp] = "R10"; n_exp++;

        while (rx_count < base + n_exp) @(negedge clk);
        for (int i = 0; i < n_exp; i++)
            check_eq(exp_tag[i], $sformatf("R6 report byte %0d", i),
                     int'(rx_buf[base + i]), int'(exp_buf[i]));

        check_eq("R5", "starts seen", (n_starts - sbase >= NT + 1) ? 1 : 0, 1);
        for (int i = 0; i < NT + 1; i++)
            check_eq(i < NT ? "R5" : "R10", $sformatf("start order entry %0d", i),
                     order_log[sbase + i], i % NT);
        check_eq("R9", "starts during a frame", r9_bad, 0);
        check_eq("R11", "trace_ready high in self-test", tr_bad, 0);
        check_eq("R3", "self-test held after strap rose", int'(selftest_active), 1);
        check_eq("R4", "framing errors self-test", frame_errs, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule